// File: doc/BRIEF.md
# Mode-Banked Architectural Register File

This block holds the sixteen general registers that a processor core sees, together with one saved status word for each exception mode. The core has several operating modes. In some of them certain register numbers reach a private physical copy instead of the shared one. An instruction always names registers 0 to 15. The block turns that number and the current mode into a physical slot, so code in an exception handler can use its own stack pointer and link register without disturbing the interrupted program's copies.

There are two combinational read ports and one write port. The write takes effect at the rising clock edge. A read of the slot being written in the same cycle returns the incoming data. A separate port reads and writes the saved status word of the current mode. The general store has 31 slots: 16 shared, 10 stack/link copies for the five exception modes, and 5 extra copies of registers 8 to 12 for the fast-interrupt mode. The saved-status store has 5 slots. Reset is active-low and clears every slot.

Top module: `mrf_top`

## Requirements
- R1: The mode input is encoded as 0 = user, 1 = system, 2 = supervisor, 3 = abort, 4 = undefined, 5 = interrupt, 6 = fast interrupt. Code 7 behaves as user. In user mode, register numbers 0 to 15 reach the shared registers.
- R2: Supervisor, abort, undefined, interrupt and fast-interrupt modes each have a private register 13 and register 14, distinct from every other mode's copies.
- R3: System mode has no private registers. It reads and writes the same registers as user mode.
- R4: A write to register 13 or 14 in an exception mode leaves the user copies unchanged.
- R5: Outside fast-interrupt mode, registers 0 to 12 reach the shared registers. Register 15 is shared in every mode.
- R6: In fast-interrupt mode, registers 8 to 12 reach private copies. Registers 0 to 7 stay shared.
- R7: When a read port addresses the register being written in the same cycle and mode, it returns the write data in that cycle.
- R8: Each of the five exception modes has its own saved status word. In user or system mode, the saved-status read returns zero and a saved-status write changes nothing.
- R9: After reset every general register and every saved status word reads as zero.
- R10: With the write enable low, no general register changes and no bypass takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 3 | Current operating mode |
| ra_addr_i | input | 4 | Read port A register number |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 4 | Read port B register number |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_addr_i | input | 4 | Write register number |
| wr_data_i | input | 32 | Write data |
| sps_wr_en_i | input | 1 | Saved-status write enable |
| sps_wr_data_i | input | 32 | Saved-status write data |
| sps_rd_data_o | output | 32 | Saved status word of the current mode |

## Verification
The bench writes distinct values into the shared registers. It then overwrites register 13 in every exception mode and reads each copy back. A remap that merges two modes' slots would return the last mode's value everywhere. A remap that leaks into the user slot would corrupt the user stack pointer seen from user and system mode. Fast-interrupt mode is checked at both ends of its banked range and one below it, which catches an off-by-one in the range that would either bank register 7 or share register 12. Same-cycle write and read is checked on one port while the other port reads a neighbouring register, and a write with the enable low is checked too. A missing or over-eager bypass shows up as stale or spurious data. Saved-status writes made in user mode must leave every exception mode's word untouched.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
    parameter int DW        = 32;
    parameter int ARCH_N    = 16;
    parameter int EXC_MODES = 5;
    parameter int SP_IDX    = 13;
    parameter int LR_IDX    = 14;
    parameter int FIQ_LO    = 8;
    parameter int FIQ_HI    = 12;

    localparam int ARCH_AW   = $clog2(ARCH_N);
    localparam int BANK_BASE = ARCH_N;
    localparam int FIQ_BASE  = BANK_BASE + 2 * EXC_MODES;
    localparam int PHYS_N    = FIQ_BASE + (FIQ_HI - FIQ_LO + 1);
    localparam int PHYS_AW   = $clog2(PHYS_N);
    localparam int SLOT_AW   = $clog2(EXC_MODES);

    typedef enum logic [2:0] {
        MD_USR = 3'd0,
        MD_SYS = 3'd1,
        MD_SVC = 3'd2,
        MD_ABT = 3'd3,
        MD_UND = 3'd4,
        MD_IRQ = 3'd5,
        MD_FIQ = 3'd6,
        MD_RSV = 3'd7
    } mode_e;

    function automatic logic mode_has_bank(logic [2:0] m);
        return (m >= 3'(MD_SVC)) && (m <= 3'(MD_FIQ));
    endfunction

    function automatic logic [SLOT_AW-1:0] mode_slot(logic [2:0] m);
        return SLOT_AW'(m - 3'(MD_SVC));
    endfunction
endpackage

// File: rtl/mrf_bank_map.sv
module mrf_bank_map
    import mrf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic [ARCH_AW-1:0] arch_i,
    output logic [PHYS_AW-1:0] phys_o
);
    logic in_sp_lr;
    logic in_fiq_hi;

    always_comb begin
        in_sp_lr  = (int'(arch_i) == SP_IDX) || (int'(arch_i) == LR_IDX);
        in_fiq_hi = (int'(arch_i) >= FIQ_LO) && (int'(arch_i) <= FIQ_HI);
        phys_o    = PHYS_AW'(arch_i);
        if (mode_has_bank(mode_i) && in_sp_lr) begin
            phys_o = PHYS_AW'(BANK_BASE + 2 * int'(mode_slot(mode_i))
                              + int'(arch_i) - SP_IDX);
        end else if ((mode_i == 3'(MD_FIQ)) && in_fiq_hi) begin
            phys_o = PHYS_AW'(FIQ_BASE + int'(arch_i) - FIQ_LO);
        end
    end

    // R5: low registers stay shared outside fast-interrupt mode
    a_r5_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 3'(MD_FIQ) && int'(arch_i) < SP_IDX) |-> (phys_o == PHYS_AW'(arch_i)));

    // R3: user and system modes never reach a banked slot
    a_r3_sys_user_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'(MD_USR) || mode_i == 3'(MD_SYS)) |-> (int'(phys_o) < ARCH_N));

    // R6: fast-interrupt mode maps 8..14 into private storage
    a_r6_fiq_private: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'(MD_FIQ) && int'(arch_i) >= FIQ_LO && int'(arch_i) <= LR_IDX)
        |-> (int'(phys_o) >= ARCH_N));
endmodule

// File: rtl/mrf_reg_store.sv
module mrf_reg_store
    import mrf_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [PHYS_AW-1:0] waddr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [PHYS_AW-1:0] raddr_i [NRD],
    output logic [DW-1:0]      rdata_o [NRD]
);
    typedef struct packed {
        logic [PHYS_N-1:0][DW-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.mem[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (we_i && (raddr_i[p] == waddr_i)) rdata_o[p] = wdata_i;
            else                                 rdata_o[p] = st_q.mem[raddr_i[p]];
        end
    end

    // R9: store is clear in the first cycle after reset
    a_r9_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (st_q.mem == '0));

    // R10: no write enable, no change of state
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(st_q.mem));
endmodule

// File: rtl/mrf_sps_bank.sv
module mrf_sps_bank
    import mrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [EXC_MODES-1:0][DW-1:0] word;
    } sps_t;

    sps_t st_d, st_q;
    logic banked;
    logic [SLOT_AW-1:0] slot;

    always_comb begin
        banked = mode_has_bank(mode_i);
        slot   = mode_slot(mode_i);
        st_d   = st_q;
        if (we_i && banked) begin
            st_d.word[slot] = wdata_i;
        end
        if (!banked)    rdata_o = '0;
        else if (we_i)  rdata_o = wdata_i;
        else            rdata_o = st_q.word[slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: user/system see zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_has_bank(mode_i) |-> (rdata_o == '0));

    // R8: a write from user/system leaves every saved word alone
    a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !mode_has_bank(mode_i)) |=> $stable(st_q.word));
endmodule

// File: rtl/mrf_top.sv
module mrf_top
    import mrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic [3:0]    ra_addr_i,
    output logic [31:0]   ra_data_o,
    input  logic [3:0]    rb_addr_i,
    output logic [31:0]   rb_data_o,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic          sps_wr_en_i,
    input  logic [31:0]   sps_wr_data_i,
    output logic [31:0]   sps_rd_data_o
);
    localparam int NRD = 2;
    localparam int NMAP = NRD + 1;

    logic [ARCH_AW-1:0] arch_idx [NMAP];
    logic [PHYS_AW-1:0] phys_idx [NMAP];
    logic [PHYS_AW-1:0] rd_phys  [NRD];
    logic [DW-1:0]      rd_data  [NRD];

    always_comb begin
        arch_idx[0] = ra_addr_i;
        arch_idx[1] = rb_addr_i;
        arch_idx[2] = wr_addr_i;
    end

    for (genvar i = 0; i < NMAP; i++) begin : g_map
        mrf_bank_map u_map (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (mode_i),
            .arch_i (arch_idx[i]),
            .phys_o (phys_idx[i])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rp
        assign rd_phys[p] = phys_idx[p];
    end

    mrf_reg_store #(.NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (phys_idx[NRD]),
        .wdata_i (wr_data_i),
        .raddr_i (rd_phys),
        .rdata_o (rd_data)
    );

    assign ra_data_o = rd_data[0];
    assign rb_data_o = rd_data[1];

    mrf_sps_bank u_sps (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .we_i    (sps_wr_en_i),
        .wdata_i (sps_wr_data_i),
        .rdata_o (sps_rd_data_o)
    );

    // R7: same-number read during a write returns the new data
    a_r7_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ra_addr_i == wr_addr_i) |-> (ra_data_o == wr_data_i));
    a_r7_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rb_addr_i == wr_addr_i) |-> (rb_data_o == wr_data_i));

    // R1: a register written is read back next cycle in the same mode
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ra_addr_i == wr_addr_i) ##1 ($stable(mode_i) && $stable(ra_addr_i))
        |-> (ra_data_o == $past(wr_data_i) || wr_en_i));
endmodule

// File: tb/mrf_top_tb_top.sv
module mrf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode;
    logic [3:0]  ra, rb, wa;
    logic [31:0] ra_d, rb_d, wd, swd, sps_d;
    logic        we, swe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          port;
        logic [31:0] exp;
    } item_t;

    item_t pend[$];

    always #10 clk = ~clk;

    mrf_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .ra_addr_i(ra), .ra_data_o(ra_d),
        .rb_addr_i(rb), .rb_data_o(rb_d),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .sps_wr_en_i(swe), .sps_wr_data_i(swd), .sps_rd_data_o(sps_d)
    );

    // monitor: compare pending expectations away from the active edge
    always @(negedge clk) begin
        while (pend.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = pend.pop_front();
            act = (it.port == 0) ? ra_d : (it.port == 1) ? rb_d : sps_d;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
            end
        end
    end

    task automatic setin(input logic [2:0] m, input logic [3:0] a, input logic [3:0] b,
                         input logic w, input logic [3:0] wad, input logic [31:0] wdat);
        mode = m; ra = a; rb = b; we = w; wa = wad; wd = wdat; swe = 1'b0; swd = '0;
    endtask

    task automatic exp_item(input string tag, input int port, input logic [31:0] v);
        item_t it;
        it.tag = tag; it.port = port; it.exp = v;
        pend.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd2(input string tag, input logic [2:0] m, input logic [3:0] a,
                       input logic [31:0] ea, input logic [3:0] b, input logic [31:0] eb);
        setin(m, a, b, 1'b0, 4'd0, 32'd0);
        exp_item(tag, 0, ea);
        exp_item(tag, 1, eb);
        tick();
    endtask

    task automatic wr(input logic [2:0] m, input logic [3:0] a, input logic [31:0] v);
        setin(m, a, a, 1'b1, a, v);
        exp_item("R7 write bypass", 0, v);
        tick();
    endtask

    task automatic sps(input string tag, input logic [2:0] m, input logic w,
                       input logic [31:0] v, input logic [31:0] e);
        setin(m, 4'd0, 4'd0, 1'b0, 4'd0, 32'd0);
        swe = w; swd = v;
        exp_item(tag, 2, e);
        tick();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        setin(3'd0, 4'd0, 4'd0, 1'b0, 4'd0, 32'd0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: cleared state
        rd2("R9 reset user", 3'd0, 4'd0, 32'd0, 4'd13, 32'd0);
        sps("R9 reset saved word", 3'd2, 1'b0, 32'd0, 32'd0);

        // R1: fill shared registers in user mode
        for (int i = 0; i < 16; i++) wr(3'd0, 4'(i), 32'h1000 + i);
        for (int i = 0; i < 16; i += 2)
            rd2("R1 user readback", 3'd0, 4'(i), 32'h1000 + i, 4'(i + 1), 32'h1001 + i);
        rd2("R1 reserved code as user", 3'd7, 4'd13, 32'h100D, 4'd9, 32'h1009);

        // R2/R4: interrupt-mode private stack/link
        wr(3'd5, 4'd13, 32'hA13);
        wr(3'd5, 4'd14, 32'hA14);
        rd2("R2 irq private", 3'd5, 4'd13, 32'hA13, 4'd14, 32'hA14);
        rd2("R4 user copies kept", 3'd0, 4'd13, 32'h100D, 4'd14, 32'h100E);
        rd2("R3 system sees user", 3'd1, 4'd13, 32'h100D, 4'd14, 32'h100E);
        rd2("R5 irq low and r15 shared", 3'd5, 4'd5, 32'h1005, 4'd15, 32'h100F);

        // R2: every exception mode distinct
        for (int m = 2; m <= 6; m++) wr(3'(m), 4'd13, 32'hB00 + m);
        for (int m = 2; m <= 6; m++)
            rd2("R2 per-mode r13", 3'(m), 4'd13, 32'hB00 + m, 4'd12,
                (m == 6) ? 32'h0 : 32'h100C);
        rd2("R4 user r13 after all", 3'd0, 4'd13, 32'h100D, 4'd15, 32'h100F);

        // R6: fast-interrupt high bank
        wr(3'd6, 4'd8, 32'hF08);
        wr(3'd6, 4'd12, 32'hF0C);
        rd2("R6 fiq banked ends", 3'd6, 4'd8, 32'hF08, 4'd12, 32'hF0C);
        rd2("R6 fiq r7 shared", 3'd6, 4'd7, 32'h1007, 4'd15, 32'h100F);
        rd2("R6 user r8 r12 kept", 3'd0, 4'd8, 32'h1008, 4'd12, 32'h100C);
        rd2("R5 svc r8 r12 shared", 3'd2, 4'd8, 32'h1008, 4'd12, 32'h100C);

        // R3: system writes land in user slot
        wr(3'd1, 4'd13, 32'h5555);
        rd2("R3 user sees system write", 3'd0, 4'd13, 32'h5555, 4'd14, 32'h100E);

        // R10: enable low
        setin(3'd0, 4'd2, 4'd3, 1'b0, 4'd2, 32'hDEAD);
        exp_item("R10 no bypass when disabled", 0, 32'h1002);
        tick();
        rd2("R10 no write when disabled", 3'd0, 4'd2, 32'h1002, 4'd3, 32'h1003);

        // R7: bypass on one port, neighbour on the other
        setin(3'd0, 4'd4, 4'd5, 1'b1, 4'd4, 32'h4444);
        exp_item("R7 bypass port a", 0, 32'h4444);
        exp_item("R7 neighbour port b", 1, 32'h1005);
        tick();
        rd2("R7 value landed", 3'd0, 4'd4, 32'h4444, 4'd5, 32'h1005);
        setin(3'd5, 4'd13, 4'd13, 1'b1, 4'd13, 32'h7777);
        exp_item("R7 banked bypass a", 0, 32'h7777);
        exp_item("R7 banked bypass b", 1, 32'h7777);
        tick();
        rd2("R4 user kept after banked write", 3'd0, 4'd13, 32'h5555, 4'd4, 32'h4444);

        // R8: saved status
        sps("R8 svc write bypass", 3'd2, 1'b1, 32'h11, 32'h11);
        sps("R8 irq write bypass", 3'd5, 1'b1, 32'h22, 32'h22);
        sps("R8 svc kept", 3'd2, 1'b0, 32'h0, 32'h11);
        sps("R8 irq kept", 3'd5, 1'b0, 32'h0, 32'h22);
        sps("R8 abt untouched", 3'd3, 1'b0, 32'h0, 32'h0);
        sps("R8 user reads zero on write", 3'd0, 1'b1, 32'h99, 32'h0);
        sps("R8 system reads zero on write", 3'd1, 1'b1, 32'h98, 32'h0);
        sps("R8 svc after user write", 3'd2, 1'b0, 32'h0, 32'h11);
        sps("R8 und after user write", 3'd4, 1'b0, 32'h0, 32'h0);
        sps("R8 fiq after user write", 3'd6, 1'b0, 32'h0, 32'h0);
        sps("R8 fiq write", 3'd6, 1'b1, 32'h33, 32'h33);
        sps("R8 fiq kept", 3'd6, 1'b0, 32'h0, 32'h33);

        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule